// File: doc/BRIEF.md
# Next-PC Sequencer with Single Delay Slot

This block holds the instruction pointer and the return-address register of a 64-bit processor with fixed 8-byte instructions. In every cycle that carries a valid instruction, it receives a decoded control kind, a 64-bit target operand and a condition-pass bit from the flag checker. It then decides where execution goes next. Branch, call and return are taken only when the condition passes. A failed condition makes them fall through like any other instruction.

A taken transfer does not move control at once. The instruction right after it, called the delay slot, always executes first. Only after that does the instruction pointer jump. Branch and call targets are word indices, so the byte address is the target shifted left by three. A call records a word index for the return: the call's own word index plus two, so the return skips the delay slot. The return-address write is presented on the ports in the same cycle as the call. A transfer that sits in a delay slot behaves as a plain instruction.

Top module: `npc_unit`

## Requirements
- R1: After reset, `fetch_pc` is 0, `link_q` is 0 and no delay slot is pending.
- R2: A valid instruction of kind 0 (sequential), or any valid instruction whose condition fails, advances `fetch_pc` by 8 at the next clock edge. A cycle with `insn_valid` low changes neither `fetch_pc` nor `link_q`.
- R3: A valid, condition-passing branch (kind 1) at address P that is not in a delay slot moves `fetch_pc` to P+8. When the delay-slot instruction is accepted, `fetch_pc` becomes `target` shifted left by 3.
- R4: A valid, condition-passing call (kind 2) at address P that is not in a delay slot raises `link_we` in that cycle with `link_data` = (P>>3)+2. `link_q` takes that value at the next edge. The call then transfers to `target`<<3 after the delay slot, like a branch.
- R5: A valid, condition-passing return (kind 3) that is not in a delay slot transfers to `link_q`<<3 after the delay slot.
- R6: A branch, call or return whose `cond_ok` is low falls through and does not raise `link_we`.
- R7: A branch, call or return accepted as a delay-slot instruction is treated as sequential. It causes no redirect and no `link_we`.
- R8: Cycles with `insn_valid` low between a taken transfer and its delay slot keep the redirect pending. It is applied when the delay slot is finally accepted.
- R9: Redirect addresses are taken modulo 2^64. Target bits shifted past bit 63 are lost, and sequential advance wraps from the top address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction at `fetch_pc` executes this cycle |
| insn_kind | input | 2 | 0 sequential, 1 branch, 2 call, 3 return |
| cond_ok | input | 1 | Condition of the instruction passes |
| target | input | 64 | Word-index target operand for branch and call |
| fetch_pc | output | 64 | Byte address of the instruction now executing |
| link_we | output | 1 | Return-address write strobe for the call in this cycle |
| link_data | output | 64 | Word index written on a call |
| link_q | output | 64 | Current return-address register |

## Verification
The hardest case to reach from the ports is a control transfer in the delay slot while the slot has been stalled by invalid cycles. For that case the pending redirect has to survive the stall, and the second transfer must be suppressed. The stimulus table sets this up: a taken branch, then an idle cycle, then a taken call in the slot. A taken branch placed in the slot of a return covers the unstalled case. A reset issued while a redirect is pending checks that the pending state is cleared.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      K_SEQ  = 2'd0,
      K_JUMP = 2'd1,
      K_LINK = 2'd2,
      K_BACK = 2'd3
   } npc_kind_e;
endpackage

// File: rtl/npc_ctl_decode.sv
module npc_ctl_decode
   import npc_pkg::*;
(
   input  logic       valid_i,
   input  logic [1:0] kind_i,
   input  logic       cond_i,
   input  logic       in_slot_i,
   output logic       arm_o,
   output logic       link_o,
   output logic       use_ra_o
);
   npc_kind_e kind;
   logic      eligible;

   always_comb begin
      kind     = npc_kind_e'(kind_i);
      eligible = valid_i && cond_i && !in_slot_i;
      arm_o    = eligible && (kind != K_SEQ);
      link_o   = eligible && (kind == K_LINK);
      use_ra_o = (kind == K_BACK);
   end
endmodule

// File: rtl/npc_addr_gen.sv
module npc_addr_gen #(
   parameter int AW      = 64,
   parameter int ALIGN   = 3,
   parameter int RA_STEP = 2
) (
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] target_i,
   input  logic [AW-1:0] ra_i,
   input  logic          use_ra_i,
   output logic [AW-1:0] seq_o,
   output logic [AW-1:0] redir_o,
   output logic [AW-1:0] link_o
);
   localparam logic [AW-1:0] STRIDE = AW'(1) << ALIGN;
   logic [AW-1:0] word_idx;

   always_comb begin
      seq_o    = pc_i + STRIDE;
      redir_o  = (use_ra_i ? ra_i : target_i) << ALIGN;
      word_idx = pc_i >> ALIGN;
   end

   generate
      if (RA_STEP == 2) begin : g_skip_slot
         assign link_o = word_idx + AW'(2);
      end else if (RA_STEP == 1) begin : g_next_word
         assign link_o = word_idx + AW'(1);
      end else begin : g_bad_step
         $error("npc_addr_gen: RA_STEP must be 1 or 2");
         assign link_o = '0;
      end
   endgenerate
endmodule

// File: rtl/npc_seq_regs.sv
module npc_seq_regs #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic          arm_i,
   input  logic          link_i,
   input  logic [AW-1:0] seq_i,
   input  logic [AW-1:0] redir_i,
   input  logic [AW-1:0] link_val_i,
   output logic [AW-1:0] pc_o,
   output logic          pend_o,
   output logic [AW-1:0] ra_o
);
   logic [AW-1:0] pend_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o      <= '0;
         pend_o    <= 1'b0;
         pend_addr <= '0;
         ra_o      <= '0;
      end else if (valid_i) begin
         if (pend_o) begin
            pc_o   <= pend_addr;
            pend_o <= 1'b0;
         end else begin
            pc_o <= seq_i;
            if (arm_i) begin
               pend_o    <= 1'b1;
               pend_addr <= redir_i;
            end
         end
         if (link_i) ra_o <= link_val_i;
      end
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int AW      = 64,
   parameter int ALIGN   = 3,
   parameter int RA_STEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          insn_valid,
   input  logic [1:0]    insn_kind,
   input  logic          cond_ok,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] fetch_pc,
   output logic          link_we,
   output logic [AW-1:0] link_data,
   output logic [AW-1:0] link_q
);
   generate
      if (ALIGN < 1 || ALIGN >= AW) begin : g_bad_align
         $error("npc_unit: ALIGN out of range");
      end
      if (AW < 8) begin : g_bad_aw
         $error("npc_unit: AW too small");
      end
   endgenerate

   logic          slot_pend;
   logic          arm, link, use_ra;
   logic [AW-1:0] seq_addr, redir_addr;

   npc_ctl_decode u_dec (
      .valid_i   (insn_valid),
      .kind_i    (insn_kind),
      .cond_i    (cond_ok),
      .in_slot_i (slot_pend),
      .arm_o     (arm),
      .link_o    (link),
      .use_ra_o  (use_ra)
   );

   npc_addr_gen #(.AW(AW), .ALIGN(ALIGN), .RA_STEP(RA_STEP)) u_gen (
      .pc_i     (fetch_pc),
      .target_i (target),
      .ra_i     (link_q),
      .use_ra_i (use_ra),
      .seq_o    (seq_addr),
      .redir_o  (redir_addr),
      .link_o   (link_data)
   );

   npc_seq_regs #(.AW(AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (insn_valid),
      .arm_i      (arm),
      .link_i     (link),
      .seq_i      (seq_addr),
      .redir_i    (redir_addr),
      .link_val_i (link_data),
      .pc_o       (fetch_pc),
      .pend_o     (slot_pend),
      .ra_o       (link_q)
   );

   assign link_we = link;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int AW    = 64,
   parameter int ALIGN = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          insn_valid,
   input logic [1:0]    insn_kind,
   input logic          cond_ok,
   input logic [AW-1:0] fetch_pc,
   input logic          link_we,
   input logic [AW-1:0] link_data,
   input logic [AW-1:0] link_q,
   input logic          slot_pend
);
   localparam logic [AW-1:0] STRIDE = AW'(1) << ALIGN;

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !slot_pend && (insn_kind == 2'd0 || !cond_ok))
      |=> fetch_pc == $past(fetch_pc) + STRIDE);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |=> ($stable(fetch_pc) && $stable(link_q)));

   assert_slot_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !slot_pend && cond_ok && insn_kind != 2'd0)
      |=> (slot_pend && fetch_pc == $past(fetch_pc) + STRIDE));

   assert_link_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |=> link_q == $past(link_data));

   assert_fail_nolink_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !cond_ok) |-> !link_we);

   assert_slot_nolink_R7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_pend |-> !link_we);

   assert_slot_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_pend && insn_valid) |=> !slot_pend);

   assert_stall_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_pend && !insn_valid) |=> slot_pend);
endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .ALIGN(ALIGN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .insn_kind  (insn_kind),
   .cond_ok    (cond_ok),
   .fetch_pc   (fetch_pc),
   .link_we    (link_we),
   .link_data  (link_data),
   .link_q     (link_q),
   .slot_pend  (slot_pend)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [1:0]  insn_kind = 2'd0;
   logic        cond_ok = 1'b0;
   logic [63:0] target = '0;
   logic [63:0] fetch_pc, link_data, link_q;
   logic        link_we;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   npc_unit u0 (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_kind(insn_kind),
      .cond_ok(cond_ok), .target(target), .fetch_pc(fetch_pc),
      .link_we(link_we), .link_data(link_data), .link_q(link_q)
   );

   typedef struct packed {
      logic        v;
      logic [1:0]  k;
      logic        c;
      logic [63:0] tgt;
      logic [63:0] pc;   // expected fetch_pc before the edge
      logic        we;
      logic [63:0] wd;
      logic [63:0] ra;   // expected link_q before the edge
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VT [NV] = '{
      '{1'b1, 2'd0, 1'b1, 64'h0,  64'h000, 1'b0, 64'h0,  64'h0},  // R2 sequential
      '{1'b1, 2'd1, 1'b1, 64'h10, 64'h008, 1'b0, 64'h0,  64'h0},  // R3 branch
      '{1'b1, 2'd0, 1'b1, 64'h0,  64'h010, 1'b0, 64'h0,  64'h0},  // R3 slot
      '{1'b1, 2'd2, 1'b1, 64'h20, 64'h080, 1'b1, 64'h12, 64'h0},  // R4 call
      '{1'b1, 2'd0, 1'b1, 64'h0,  64'h088, 1'b0, 64'h0,  64'h12}, // R4 slot
      '{1'b1, 2'd1, 1'b0, 64'h7,  64'h100, 1'b0, 64'h0,  64'h12}, // R6 branch fails
      '{1'b1, 2'd2, 1'b0, 64'h7,  64'h108, 1'b0, 64'h0,  64'h12}, // R6 call fails
      '{1'b1, 2'd3, 1'b1, 64'h5,  64'h110, 1'b0, 64'h0,  64'h12}, // R5 return
      '{1'b1, 2'd1, 1'b1, 64'h40, 64'h118, 1'b0, 64'h0,  64'h12}, // R7 branch in slot
      '{1'b0, 2'd0, 1'b1, 64'h0,  64'h090, 1'b0, 64'h0,  64'h12}, // R2 idle
      '{1'b1, 2'd1, 1'b1, 64'h3,  64'h090, 1'b0, 64'h0,  64'h12}, // R8 branch
      '{1'b0, 2'd2, 1'b1, 64'h9,  64'h098, 1'b0, 64'h0,  64'h12}, // R8 stall
      '{1'b1, 2'd2, 1'b1, 64'h9,  64'h098, 1'b0, 64'h0,  64'h12}, // R7 call in slot
      '{1'b1, 2'd0, 1'b1, 64'h0,  64'h018, 1'b0, 64'h0,  64'h12}  // R8 landed
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [1:0] k, input logic c, input logic [63:0] t);
      insn_valid = v; insn_kind = k; cond_ok = c; target = t;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 pc", fetch_pc, 64'h0);
      chk("R1 link", link_q, 64'h0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         chk($sformatf("R2-R8 vec%0d pc", i), fetch_pc, VT[i].pc);
         chk($sformatf("R4 vec%0d link_q", i), link_q, VT[i].ra);
         drive(VT[i].v, VT[i].k, VT[i].c, VT[i].tgt);
         #1;
         chk($sformatf("R6/R7 vec%0d link_we", i), {63'b0, link_we}, {63'b0, VT[i].we});
         if (VT[i].we) chk($sformatf("R4 vec%0d link_data", i), link_data, VT[i].wd);
      end
      @(negedge clk);
      chk("R8 final pc", fetch_pc, 64'h020);

      // R1: reset while a redirect is pending clears it
      drive(1'b1, 2'd1, 1'b1, 64'h50);
      @(negedge clk);
      drive(1'b0, 2'd0, 1'b0, 64'h0);
      rst_n = 1'b0;
      #1;
      chk("R1 async pc", fetch_pc, 64'h0);
      chk("R1 async link", link_q, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, 2'd0, 1'b1, 64'h0);
      @(negedge clk);
      drive(1'b1, 2'd0, 1'b1, 64'h0);
      @(negedge clk);
      chk("R1 no pending after reset", fetch_pc, 64'h010);

      // R9: target truncation and wrap of sequential advance
      drive(1'b1, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      drive(1'b1, 2'd0, 1'b1, 64'h0);
      @(negedge clk);
      chk("R9 truncated target", fetch_pc, 64'hFFFF_FFFF_FFFF_FFF8);
      drive(1'b1, 2'd0, 1'b1, 64'h0);
      @(negedge clk);
      chk("R9 wrap", fetch_pc, 64'h0);

      // R4: call near the top of memory wraps the link word index
      drive(1'b1, 2'd1, 1'b1, 64'h1FFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      drive(1'b1, 2'd0, 1'b1, 64'h0);
      @(negedge clk);
      drive(1'b1, 2'd2, 1'b1, 64'h4);
      #1;
      chk("R4 link_we high", {63'b0, link_we}, 64'h1);
      chk("R4 link_data wrap", link_data, 64'h2000_0000_0000_0001);
      @(negedge clk);
      chk("R4 link_q", link_q, 64'h2000_0000_0000_0001);
      drive(1'b1, 2'd3, 1'b1, 64'h0); // return in call's slot is ignored
      #1;
      chk("R7 no link in slot", {63'b0, link_we}, 64'h0);
      @(negedge clk);
      chk("R4 call landed", fetch_pc, 64'h20);
      drive(1'b1, 2'd3, 1'b1, 64'h0);
      @(negedge clk);
      drive(1'b1, 2'd0, 1'b1, 64'h0);
      @(negedge clk);
      chk("R5 return with truncation", fetch_pc, 64'h8);
      drive(1'b0, 2'd0, 1'b0, 64'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule